// File: doc/BRIEF.md
# Reorder Buffer with Precise Commit

This block keeps the instructions that are in flight in the order they were issued, so that a core that executes out of order still retires them one at a time in program order. The front end claims a slot for each instruction as it is issued and gets back the slot index. Execution units later post a result or a fault cause to that index, in any order. The entry at the oldest position is the only one that may leave the buffer. A finished result is published on the commit port. A faulted entry raises an exception that carries its cause, slot and tag, and the whole buffer is emptied.

A branch-mispredict input names the slot of the resolving branch. Every entry younger than that slot is discarded before it can reach the oldest position, so any fault such an entry recorded is never reported. The block holds only speculative results. Renaming, issue, the execution units and the architectural register file lie outside it.

Top module: `rob_commit_queue`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_slot` is 0, and `cmt_valid` and `exc_valid` are both 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready` both high at a clock edge) takes slot `alloc_slot`. Slots are handed out in increasing order modulo DEPTH. `alloc_slot` does not change without an allocation, a flush or a squash. While DEPTH entries are in flight, `alloc_ready` is 0.
- R3: `alloc_ready` is 0 in any cycle in which `mis_valid` or `exc_valid` is high.
- R4: A completion (`cmp_valid`, `cmp_slot`, with `cmp_fault` 1 for a fault and 0 for a result) may arrive for any in-flight slot in any order. A completion to an entry that is not the oldest never causes a commit or an exception by itself.
- R5: When the oldest entry holds a result, `cmt_valid` is high in that cycle, together with the entry's tag on `cmt_id` and its result on `cmt_data`. The entry then leaves at the clock edge. At most one entry leaves per cycle, and `cmt_valid` and `exc_valid` are never high together.
- R6: When the oldest entry has not completed, or the buffer is empty, neither `cmt_valid` nor `exc_valid` is high.
- R7: When the oldest entry is faulted, `exc_valid` is high with `exc_cause`, `exc_slot` and `exc_id` taken from that entry. At the clock edge every entry is discarded, including younger entries that already completed, and the next allocation reuses slot `exc_slot`.
- R8: A mispredict (`mis_valid`) that names an in-flight slot S discards every entry younger than S and keeps S and everything older. The next allocation gets slot S+1 modulo DEPTH. A mispredict that names a slot not in flight changes nothing.
- R9: A fault recorded by an entry that a mispredict discards is never reported. A completion that targets a slot not in flight, or a slot discarded in the same cycle, is ignored.
- R10: When a faulted oldest entry and a mispredict occur in the same cycle, the exception is taken and the buffer is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alloc_valid | input | 1 | Request to allocate a slot for the next instruction in program order |
| alloc_id | input | ID_W | Instruction tag stored in the allocated slot |
| alloc_ready | output | 1 | Allocation is accepted in this cycle |
| alloc_slot | output | log2(DEPTH) | Slot index granted to the allocation |
| cmp_valid | input | 1 | Completion from an execution unit |
| cmp_slot | input | log2(DEPTH) | Slot being completed |
| cmp_fault | input | 1 | 1 for a fault, 0 for a normal result |
| cmp_cause | input | CAUSE_W | Fault cause code |
| cmp_data | input | DATA_W | Speculative result |
| mis_valid | input | 1 | Branch mispredict resolved |
| mis_slot | input | log2(DEPTH) | Slot of the mispredicted branch; younger entries are discarded |
| cmt_valid | output | 1 | Oldest entry commits in this cycle |
| cmt_id | output | ID_W | Tag of the committing entry |
| cmt_data | output | DATA_W | Result of the committing entry |
| exc_valid | output | 1 | Precise exception raised by the oldest entry |
| exc_cause | output | CAUSE_W | Cause code of the exception |
| exc_slot | output | log2(DEPTH) | Slot of the faulting entry |
| exc_id | output | ID_W | Tag of the faulting entry |

## Verification
Assertions check four things on every cycle. Accepted allocations step `alloc_slot` by one, and the slot holds still when nothing moves the tail. Allocation is blocked while a mispredict or an exception is present. Commit and exception never coincide. After a flush or a squash the tail lands on the faulting slot, or on the slot just past the branch. Only the bench's scenarios can show the rest, because it is about data flowing between ports over many cycles. That covers the retired tags and results matching program order whatever order the completions come in, faults from discarded entries staying silent, and completions to stale slots leaving no trace. The bench compares every cycle against an in-order reference model, first over directed sequences and then over a long pseudo-random mix on a four-entry buffer.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    SLOT_WAIT  = 2'd0,
    SLOT_DONE  = 2'd1,
    SLOT_FAULT = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             retire_en,
  input  logic             flush_en,
  input  logic             squash_req,
  input  logic [IDX_W-1:0] squash_slot,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty,
  output logic             squash_hit,
  output logic [DEPTH-1:0] keep_mask
);
  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [PTR_W-1:0] occ;
  logic [IDX_W-1:0] squash_off;

  assign head_idx   = head_q[IDX_W-1:0];
  assign tail_idx   = tail_q[IDX_W-1:0];
  assign occ        = tail_q - head_q;
  assign full       = (occ == PTR_W'(DEPTH));
  assign empty      = (occ == '0);
  assign squash_off = squash_slot - head_idx;
  assign squash_hit = squash_req && ({1'b0, squash_off} < occ);

  // A slot survives this cycle if it is in flight, no flush is under way,
  // and it is not younger than a squashing branch.
  for (genvar i = 0; i < DEPTH; i++) begin : g_keep
    logic [IDX_W-1:0] slot_off;
    assign slot_off     = IDX_W'(i) - head_idx;
    assign keep_mask[i] = ({1'b0, slot_off} < occ) && !flush_en &&
                          !(squash_hit && (slot_off > squash_off));
  end

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (retire_en) head_d = head_q + PTR_W'(1);
    if (flush_en) begin
      tail_d = head_q;
    end else if (squash_hit) begin
      tail_d = head_q + {1'b0, squash_off} + PTR_W'(1);
    end else if (alloc_en) begin
      tail_d = tail_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end
endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store
  import rob_pkg::*;
#(
  parameter  int DEPTH   = 8,
  parameter  int ID_W    = 8,
  parameter  int DATA_W  = 32,
  parameter  int CAUSE_W = 5,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic [ID_W-1:0]    alloc_id,
  input  logic               cmp_valid,
  input  logic [IDX_W-1:0]   cmp_slot,
  input  logic               cmp_fault,
  input  logic [CAUSE_W-1:0] cmp_cause,
  input  logic [DATA_W-1:0]  cmp_data,
  input  logic [DEPTH-1:0]   keep_mask,
  input  logic [IDX_W-1:0]   head_idx,
  output slot_state_e        head_state,
  output logic [ID_W-1:0]    head_id,
  output logic [DATA_W-1:0]  head_data,
  output logic [CAUSE_W-1:0] head_cause
);
  slot_state_e        st_arr    [DEPTH];
  logic [ID_W-1:0]    id_arr    [DEPTH];
  logic [DATA_W-1:0]  data_arr  [DEPTH];
  logic [CAUSE_W-1:0] cause_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    slot_state_e        state_q, state_d;
    logic [ID_W-1:0]    id_q;
    logic [DATA_W-1:0]  data_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               alloc_hit, cmp_hit;

    assign alloc_hit = alloc_en && (alloc_idx == IDX_W'(i));
    assign cmp_hit   = cmp_valid && (cmp_slot == IDX_W'(i)) && keep_mask[i];

    always_comb begin
      state_d = state_q;
      if (alloc_hit)    state_d = SLOT_WAIT;
      else if (cmp_hit) state_d = cmp_fault ? SLOT_FAULT : SLOT_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SLOT_WAIT;
      else        state_q <= state_d;
    end

    // Payload registers carry no reset; they are only read once status
    // marks them written.
    always_ff @(posedge clk) begin
      if (alloc_hit) id_q <= alloc_id;
      if (cmp_hit) begin
        data_q  <= cmp_data;
        cause_q <= cmp_cause;
      end
    end

    assign st_arr[i]    = state_q;
    assign id_arr[i]    = id_q;
    assign data_arr[i]  = data_q;
    assign cause_arr[i] = cause_q;
  end

  assign head_state = st_arr[head_idx];
  assign head_id    = id_arr[head_idx];
  assign head_data  = data_arr[head_idx];
  assign head_cause = cause_arr[head_idx];
endmodule

// File: rtl/rob_head_gate.sv
module rob_head_gate
  import rob_pkg::*;
(
  input  logic        empty,
  input  slot_state_e head_state,
  output logic        retire,
  output logic        fault
);
  always_comb begin
    retire = 1'b0;
    fault  = 1'b0;
    if (!empty) begin
      unique case (head_state)
        SLOT_DONE:  retire = 1'b1;
        SLOT_FAULT: fault  = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/rob_commit_queue.sv
module rob_commit_queue
  import rob_pkg::*;
#(
  parameter  int DEPTH   = 8,
  parameter  int ID_W    = 8,
  parameter  int DATA_W  = 32,
  parameter  int CAUSE_W = 5,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [ID_W-1:0]    alloc_id,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_slot,
  input  logic               cmp_valid,
  input  logic [IDX_W-1:0]   cmp_slot,
  input  logic               cmp_fault,
  input  logic [CAUSE_W-1:0] cmp_cause,
  input  logic [DATA_W-1:0]  cmp_data,
  input  logic               mis_valid,
  input  logic [IDX_W-1:0]   mis_slot,
  output logic               cmt_valid,
  output logic [ID_W-1:0]    cmt_id,
  output logic [DATA_W-1:0]  cmt_data,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [IDX_W-1:0]   exc_slot,
  output logic [ID_W-1:0]    exc_id
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [IDX_W-1:0]   head_idx, tail_idx;
  logic               full, empty, squash_hit;
  logic [DEPTH-1:0]   keep_mask;
  logic               do_alloc, head_retire, head_fault;
  slot_state_e        head_state;
  logic [ID_W-1:0]    head_id;
  logic [DATA_W-1:0]  head_data;
  logic [CAUSE_W-1:0] head_cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign alloc_ready = !full && !mis_valid && !head_fault;
  assign do_alloc    = alloc_valid && alloc_ready;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) i_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .alloc_en   (do_alloc),
    .retire_en  (head_retire),
    .flush_en   (head_fault),
    .squash_req (mis_valid),
    .squash_slot(mis_slot),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .full       (full),
    .empty      (empty),
    .squash_hit (squash_hit),
    .keep_mask  (keep_mask)
  );

  rob_slot_store #(
    .DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
  ) i_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .alloc_en  (do_alloc),
    .alloc_idx (tail_idx),
    .alloc_id  (alloc_id),
    .cmp_valid (cmp_valid),
    .cmp_slot  (cmp_slot),
    .cmp_fault (cmp_fault),
    .cmp_cause (cmp_cause),
    .cmp_data  (cmp_data),
    .keep_mask (keep_mask),
    .head_idx  (head_idx),
    .head_state(head_state),
    .head_id   (head_id),
    .head_data (head_data),
    .head_cause(head_cause)
  );

  rob_head_gate i_gate (
    .empty     (empty),
    .head_state(head_state),
    .retire    (head_retire),
    .fault     (head_fault)
  );

  assign alloc_slot = tail_idx;
  assign cmt_valid  = head_retire;
  assign cmt_id     = head_id;
  assign cmt_data   = head_data;
  assign exc_valid  = head_fault;
  assign exc_cause  = head_cause;
  assign exc_slot   = head_idx;
  assign exc_id     = head_id;
endmodule

// File: rtl/rob_commit_checker.sv
module rob_commit_checker #(
  parameter  int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_slot,
  input logic             mis_valid,
  input logic [IDX_W-1:0] mis_slot,
  input logic             squash_hit,
  input logic             cmt_valid,
  input logic             exc_valid,
  input logic [IDX_W-1:0] exc_slot
);
  assert_alloc_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_slot == IDX_W'($past(alloc_slot) + 1'b1)));

  assert_tail_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(alloc_valid && alloc_ready) && !exc_valid && !squash_hit) |=> $stable(alloc_slot));

  assert_no_alloc_on_redirect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mis_valid || exc_valid) |-> !alloc_ready);

  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmt_valid && exc_valid));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (!cmt_valid && !exc_valid && alloc_slot == $past(exc_slot)));

  assert_squash_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_hit && !exc_valid) |=> (alloc_slot == IDX_W'($past(mis_slot) + 1'b1)));
endmodule

bind rob_commit_queue rob_commit_checker #(.DEPTH(DEPTH)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready),
  .alloc_slot (alloc_slot),
  .mis_valid  (mis_valid),
  .mis_slot   (mis_slot),
  .squash_hit (squash_hit),
  .cmt_valid  (cmt_valid),
  .exc_valid  (exc_valid),
  .exc_slot   (exc_slot)
);

// File: tb/test_rob_commit_queue.sv
module test_rob_commit_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH   = 4;
  localparam int ID_W    = 8;
  localparam int DATA_W  = 16;
  localparam int CAUSE_W = 4;
  localparam int IDX_W   = $clog2(DEPTH);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               alloc_valid;
  logic [ID_W-1:0]    alloc_id;
  logic               alloc_ready;
  logic [IDX_W-1:0]   alloc_slot;
  logic               cmp_valid;
  logic [IDX_W-1:0]   cmp_slot;
  logic               cmp_fault;
  logic [CAUSE_W-1:0] cmp_cause;
  logic [DATA_W-1:0]  cmp_data;
  logic               mis_valid;
  logic [IDX_W-1:0]   mis_slot;
  logic               cmt_valid;
  logic [ID_W-1:0]    cmt_id;
  logic [DATA_W-1:0]  cmt_data;
  logic               exc_valid;
  logic [CAUSE_W-1:0] exc_cause;
  logic [IDX_W-1:0]   exc_slot;
  logic [ID_W-1:0]    exc_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_commit_queue #(
    .DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)
  ) i_rob_commit_queue (.*);

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model: status 0 waiting, 1 result, 2 fault.
  int m_st    [DEPTH];
  int m_id    [DEPTH];
  int m_data  [DEPTH];
  int m_cause [DEPTH];
  int m_head = 0;
  int m_tail = 0;
  int next_id = 1;
  int unsigned rng = 32'h1234_5678;

  function automatic int rnd(int lim);
    rng = rng * 32'd1103515245 + 32'd12345;
    return int'((rng >> 16) & 32'h7fff) % lim;
  endfunction

  task automatic chk(input bit ok, input string tag, input string ctx,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s): actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  function automatic int offs(int s);
    return (s - (m_head % DEPTH) + DEPTH) % DEPTH;
  endfunction

  task automatic step(input bit av, input bit cv, input int cs, input bit cf,
                      input int cc, input int cd, input bit mv, input int ms,
                      input string ctx);
    int occ, h, aid;
    bit e_exc, e_cmt, e_ready, hit;
    string tg;
    aid = next_id % 256;
    alloc_valid = av;  alloc_id  = ID_W'(aid);
    cmp_valid   = cv;  cmp_slot  = IDX_W'(cs);  cmp_fault = cf;
    cmp_cause   = CAUSE_W'(cc);  cmp_data = DATA_W'(cd);
    mis_valid   = mv;  mis_slot  = IDX_W'(ms);
    #1;
    occ = m_tail - m_head;
    h   = m_head % DEPTH;
    e_exc   = (occ > 0) && (m_st[h] == 2);
    e_cmt   = (occ > 0) && (m_st[h] == 1);
    e_ready = (occ < DEPTH) && !mv && !e_exc;
    chk(alloc_ready === e_ready, (occ == DEPTH) ? "R2" : "R3", ctx,
        int'(alloc_ready), int'(e_ready));
    if (e_ready) chk(alloc_slot == IDX_W'(m_tail % DEPTH), "R2", ctx,
                     int'(alloc_slot), m_tail % DEPTH);
    tg = e_cmt ? "R5" : (occ == 0 ? "R1" : (m_st[h] == 0 ? "R6" : "R7"));
    chk(cmt_valid === e_cmt, tg, ctx, int'(cmt_valid), int'(e_cmt));
    if (e_cmt) begin
      chk(cmt_id == ID_W'(m_id[h]), "R5", ctx, int'(cmt_id), m_id[h]);
      chk(cmt_data == DATA_W'(m_data[h]), "R5", ctx, int'(cmt_data), m_data[h]);
    end
    chk(exc_valid === e_exc, e_exc ? "R7" : tg, ctx, int'(exc_valid), int'(e_exc));
    if (e_exc) begin
      chk(exc_cause == CAUSE_W'(m_cause[h]), "R7", ctx, int'(exc_cause), m_cause[h]);
      chk(exc_slot == IDX_W'(h), "R7", ctx, int'(exc_slot), h);
      chk(exc_id == ID_W'(m_id[h]), "R7", ctx, int'(exc_id), m_id[h]);
    end
    // Model update for the coming edge.
    hit = mv && (offs(ms) < occ);
    if (cv && offs(cs) < occ && !e_exc && !(hit && offs(cs) > offs(ms))) begin
      m_st[cs]    = cf ? 2 : 1;
      m_data[cs]  = cd % (1 << DATA_W);
      m_cause[cs] = cc % (1 << CAUSE_W);
    end
    if (av && e_ready) begin
      m_st[m_tail % DEPTH] = 0;
      m_id[m_tail % DEPTH] = aid;
      next_id++;
    end
    if (e_exc)         m_tail = m_head;
    else if (hit)      m_tail = m_head + offs(ms) + 1;
    else if (av && e_ready) m_tail = m_tail + 1;
    if (e_cmt) m_head = m_head + 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string ctx);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, ctx);
  endtask

  initial begin
    int s;
    alloc_valid = 0; alloc_id = '0; cmp_valid = 0; cmp_slot = '0;
    cmp_fault = 0; cmp_cause = '0; cmp_data = '0; mis_valid = 0; mis_slot = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(alloc_ready === 1'b1, "R1", "reset ready", int'(alloc_ready), 1);
    chk(alloc_slot == '0, "R1", "reset slot", int'(alloc_slot), 0);
    chk(cmt_valid === 1'b0, "R1", "reset commit", int'(cmt_valid), 0);
    chk(exc_valid === 1'b0, "R1", "reset exception", int'(exc_valid), 0);
    @(negedge clk);

    // R4/R5: completions out of order, retirement in order.
    s = m_tail % DEPTH;
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 0, 0, "R5 fill");
    step(0, 1, (s + 2) % DEPTH, 0, 0, 16'h0222, 0, 0, "R4 youngest first");
    step(0, 1, (s + 1) % DEPTH, 0, 0, 16'h0111, 0, 0, "R4 middle");
    step(0, 1, s, 0, 0, 16'h0aaa, 0, 0, "R4 oldest last");
    idle(4, "R5 drain");

    // R2: fill to capacity, refuse one more.
    s = m_tail % DEPTH;
    for (int k = 0; k < DEPTH + 1; k++) step(1, 0, 0, 0, 0, 0, 0, 0, "R2 overfill");
    for (int k = 0; k < DEPTH; k++)
      step(0, 1, (s + k) % DEPTH, 0, 0, 100 + k, 0, 0, "R5 complete");
    idle(DEPTH + 1, "R6 drain");

    // R7: faulted oldest with a finished younger entry.
    s = m_tail % DEPTH;
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 0, 0, "R7 fill");
    step(0, 1, (s + 1) % DEPTH, 0, 0, 16'h5555, 0, 0, "R7 younger done");
    step(0, 1, s, 1, 5, 0, 0, 0, "R7 oldest fault");
    idle(3, "R7 after flush");

    // R8/R9: discarded faults stay silent, same-cycle completion ignored.
    s = m_tail % DEPTH;
    for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, 0, 0, "R9 fill");
    step(0, 1, (s + 2) % DEPTH, 1, 7, 0, 0, 0, "R9 wrong-path fault");
    step(0, 1, (s + 1) % DEPTH, 1, 3, 0, 1, s, "R9 squash with completion");
    step(0, 1, (s + 1) % DEPTH, 1, 4, 0, 0, 0, "R9 stale slot completion");
    step(0, 1, s, 0, 0, 16'h0bbb, 0, 0, "R8 branch done");
    idle(3, "R9 no exception");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 next slot");
    step(0, 0, 0, 0, 0, 0, 1, (m_tail + 2) % DEPTH, "R8 mispredict not in flight");
    step(0, 1, m_head % DEPTH, 0, 0, 9, 0, 0, "R8 finish");
    idle(2, "R8 drain");

    // R10: faulted oldest and mispredict together.
    s = m_tail % DEPTH;
    step(1, 0, 0, 0, 0, 0, 0, 0, "R10 fill");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R10 fill");
    step(0, 1, s, 1, 9, 0, 0, 0, "R10 fault");
    step(0, 0, 0, 0, 0, 0, 1, s, "R10 both");
    idle(2, "R10 after");

    // Pseudo-random mix against the reference model.
    for (int k = 0; k < 6000; k++) begin
      int cs;
      bit av, cv, cf, mv;
      av = rnd(10) < 6;
      cv = rnd(10) < 7;
      cs = rnd(DEPTH);
      cf = rnd(8) == 0;
      mv = rnd(14) == 0;
      step(av, cv, cs, cf, rnd(16), rnd(65536), mv, rnd(DEPTH), "R4 R8 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule